// File: doc/BRIEF.md
# Locked Indexed Configuration Register Port

This block is the byte-wide configuration register file of a chipset. Software reaches it through two I/O ports. A write to the index port selects one of 256 register slots. A read or write on the data port then moves a byte to or from the selected slot. Only the key slot and one contiguous window of configuration slots hold storage. Every other slot reads back as zero.

Writes to the configuration window are refused until the key slot holds a fixed unlock byte. The key slot itself can be written at any time, so software can unlock and relock the window. Each slot applies its own write mask when data arrives, so bits that are reserved always stay zero. A compatibility input hides certain slots from data-port reads, so the block can share its ports with registers that sit inside some processors. The block drives the values of the shadow, SMM, interrupt-routing and fast-reset slots to the blocks around it.

Top module: `cfg_index_port`

## Requirements
- R1: A write to I/O address 0x0022 loads the 8-bit index. A read at 0x0022 returns the current index.
- R2: A data-port write (address 0x0023) to any slot other than the key slot 0x03 changes storage only while slot 0x03 holds 0xC5. While the port is locked, such writes leave every slot unchanged.
- R3: A data-port write to key slot 0x03 is always stored in full, whether the port is locked or unlocked.
- R4: The write masks are: 0x14 and 0x2B use 0xBF, 0x15 uses 0xF1, 0x1E uses 0x40, 0x22 uses 0xFD, 0x36 uses 0xE5, 0x37 uses 0xEF, 0x3D uses 0x07, and 0x40 uses 0x3F. The stored value is the written byte ANDed with the mask.
- R5: Slots in the window 0x10..0x44 that have no listed mask store all 8 bits. Slots outside that window, other than 0x03, read back as 0x00.
- R6: While compat_mode is 1, a data-port read at index 0x20 or at any index of 0xC0 or above returns 0xFF. The stored contents are not affected.
- R7: After reset, slot 0x3C reads 0x03, slot 0x3D reads 0x01 and slot 0x40 reads 0x03. Slot 0x03, the index and all other slots read 0x00.
- R8: irq_route[3:0] is the low nibble of slot 0x42 (line A) and irq_route[7:4] is its high nibble (line B). irq_route[11:8] and irq_route[15:12] come in the same way from slot 0x43 (lines C and D). irq_route_en bit n is 1 exactly when nibble n is nonzero.
- R9: fast_reset_en is bit 4 of slot 0x29. shadow_region, shadow_ctrl and smm_ctrl are the stored values of slots 0x13, 0x14 and 0x19.
- R10: A read at any I/O address other than 0x0022 and 0x0023 returns 0xFF. A write at such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| compat_mode | input | 1 | Hides slot 0x20 and slots 0xC0 and above from data reads |
| shadow_region | output | 8 | Stored value of slot 0x13 |
| shadow_ctrl | output | 8 | Stored value of slot 0x14 |
| smm_ctrl | output | 8 | Stored value of slot 0x19 |
| irq_route | output | 16 | Four 4-bit interrupt selections, line A in the low nibble |
| irq_route_en | output | 4 | Per-line enable, 1 when its selection is nonzero |
| fast_reset_en | output | 1 | Enable for the fast-reset and A20 control port |

## Verification
The bench builds the block with its default parameters. These are ports 0x0022/0x0023, key slot 0x03 with unlock byte 0xC5, and storage window 0x10..0x44. With these values every masked slot, every output tap and a slot just beyond the window can be reached from a single vector table. The same defaults place the hidden slot 0x20 inside the window, so a stored byte can be seen both hidden and revealed. Index 0xC0 lies outside the window, so the compatibility rule can be told apart from the read-as-zero rule there.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

   localparam int BYTE_W = 8;

   // Write mask applied to a byte entering the given slot.
   function automatic logic [7:0] slot_mask(input logic [7:0] idx);
      case (idx)
         8'h14, 8'h2B: slot_mask = 8'hBF;
         8'h15:        slot_mask = 8'hF1;
         8'h1E:        slot_mask = 8'h40;
         8'h22:        slot_mask = 8'hFD;
         8'h36:        slot_mask = 8'hE5;
         8'h37:        slot_mask = 8'hEF;
         8'h3D:        slot_mask = 8'h07;
         8'h40:        slot_mask = 8'h3F;
         default:      slot_mask = 8'hFF;
      endcase
   endfunction

   // Value a slot takes on reset.
   function automatic logic [7:0] slot_reset(input logic [7:0] idx);
      case (idx)
         8'h3C:   slot_reset = 8'h03;
         8'h3D:   slot_reset = 8'h01;
         8'h40:   slot_reset = 8'h03;
         default: slot_reset = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/cfgp_index.sv
module cfgp_index #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] data_i,
   output logic [IDX_W-1:0] index_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      index_o <= '0;
      else if (load_i) index_o <= data_i;
   end

   // R1
   index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> index_o == $past(data_i));
endmodule

// File: rtl/cfgp_key.sv
module cfgp_key #(
   parameter int         DW        = 8,
   parameter logic [7:0] UNLOCK_KEY = 8'hC5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] key_o,
   output logic          unlock_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    key_o <= '0;
      else if (wr_i) key_o <= data_i;
   end

   assign unlock_o = (key_o == DW'(UNLOCK_KEY));

   // R3
   key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> key_o == $past(data_i));
endmodule

// File: rtl/cfgp_reg_bank.sv
module cfgp_reg_bank
   import cfgp_pkg::*;
#(
   parameter int LO = 8'h10,
   parameter int HI = 8'h44,
   localparam int NREG = HI - LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unlock_i,
   input  logic              wr_i,
   input  logic [7:0]        wr_idx_i,
   input  logic [7:0]        wr_data_i,
   input  logic [7:0]        rd_idx_i,
   output logic [7:0]        rd_data_o,
   output logic [NREG*8-1:0] bank_o
);
   generate
      if (LO < 0 || HI > 255 || HI < LO) begin : g_bad_range
         $error("cfgp_reg_bank: window out of range");
      end
   endgenerate

   for (genvar g = 0; g < NREG; g++) begin : g_slot
      localparam logic [7:0] IDX  = 8'(LO + g);
      localparam logic [7:0] MASK = slot_mask(IDX);
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= slot_reset(IDX);
         else if (wr_i && wr_idx_i == IDX)
            q <= wr_data_i & MASK;
      end
      assign bank_o[g*8 +: 8] = q;

      // R4
      mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (q & ~MASK) == 8'h00);
   end

   logic       in_win;
   logic [7:0] off;
   assign in_win = (int'(rd_idx_i) >= LO) && (int'(rd_idx_i) <= HI);
   assign off    = rd_idx_i - 8'(LO);
   assign rd_data_o = in_win ? bank_o[int'(off)*8 +: 8] : 8'h00;

   // R2
   locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlock_i |=> $stable(bank_o));
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfgp_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] INDEX_PORT = 16'h0022,
   parameter logic [15:0] DATA_PORT  = 16'h0023,
   parameter logic [7:0]  KEY_IDX    = 8'h03,
   parameter logic [7:0]  UNLOCK_KEY = 8'hC5,
   parameter int          WIN_LO     = 8'h10,
   parameter int          WIN_HI     = 8'h44,
   parameter int          TAP_SHREG  = 8'h13,
   parameter int          TAP_SHCTL  = 8'h14,
   parameter int          TAP_SMM    = 8'h19,
   parameter int          TAP_FRST   = 8'h29,
   parameter int          TAP_IRQLO  = 8'h42,
   parameter int          TAP_IRQHI  = 8'h43,
   parameter int          FRST_BIT   = 4,
   localparam int         NREG       = WIN_HI - WIN_LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              compat_mode,
   output logic [7:0]        shadow_region,
   output logic [7:0]        shadow_ctrl,
   output logic [7:0]        smm_ctrl,
   output logic [15:0]       irq_route,
   output logic [3:0]        irq_route_en,
   output logic              fast_reset_en
);
   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_aw
         $error("cfg_index_port: ADDR_W must be 8..16");
      end
      if (int'(KEY_IDX) >= WIN_LO && int'(KEY_IDX) <= WIN_HI) begin : g_bad_key
         $error("cfg_index_port: key slot inside storage window");
      end
      if (TAP_SHREG < WIN_LO || TAP_SMM > WIN_HI || TAP_IRQHI > WIN_HI ||
          TAP_FRST < WIN_LO || TAP_FRST > WIN_HI || FRST_BIT > 7) begin : g_bad_tap
         $error("cfg_index_port: output tap outside window");
      end
   endgenerate

   logic       hit_idx, hit_dat;
   logic [7:0] index_q, key_q, bank_rd;
   logic       unlock;
   logic [NREG*8-1:0] bank;

   assign hit_idx = (io_addr == ADDR_W'(INDEX_PORT));
   assign hit_dat = (io_addr == ADDR_W'(DATA_PORT));

   cfgp_index #(.IDX_W(8)) u_index (
      .clk(clk), .rst_n(rst_n), .load_i(io_wr && hit_idx),
      .data_i(io_wdata), .index_o(index_q));

   cfgp_key #(.DW(8), .UNLOCK_KEY(UNLOCK_KEY)) u_key (
      .clk(clk), .rst_n(rst_n), .wr_i(io_wr && hit_dat && index_q == KEY_IDX),
      .data_i(io_wdata), .key_o(key_q), .unlock_o(unlock));

   cfgp_reg_bank #(.LO(WIN_LO), .HI(WIN_HI)) u_bank (
      .clk(clk), .rst_n(rst_n), .unlock_i(unlock),
      .wr_i(io_wr && hit_dat && unlock && index_q != KEY_IDX),
      .wr_idx_i(index_q), .wr_data_i(io_wdata),
      .rd_idx_i(index_q), .rd_data_o(bank_rd), .bank_o(bank));

   logic hidden;
   assign hidden = compat_mode && (index_q == 8'h20 || index_q >= 8'hC0);

   always_comb begin
      if (hit_idx)                    io_rdata = index_q;
      else if (!hit_dat)              io_rdata = 8'hFF;
      else if (hidden)                io_rdata = 8'hFF;
      else if (index_q == KEY_IDX)    io_rdata = key_q;
      else                            io_rdata = bank_rd;
   end

   assign shadow_region = bank[(TAP_SHREG-WIN_LO)*8 +: 8];
   assign shadow_ctrl   = bank[(TAP_SHCTL-WIN_LO)*8 +: 8];
   assign smm_ctrl      = bank[(TAP_SMM-WIN_LO)*8 +: 8];
   assign fast_reset_en = bank[(TAP_FRST-WIN_LO)*8 + FRST_BIT];
   assign irq_route     = {bank[(TAP_IRQHI-WIN_LO)*8 +: 8],
                           bank[(TAP_IRQLO-WIN_LO)*8 +: 8]};

   for (genvar n = 0; n < 4; n++) begin : g_irq_en
      assign irq_route_en[n] = |irq_route[n*4 +: 4];
   end

   // R6
   compat_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (compat_mode && hit_dat && (index_q == 8'h20 || index_q >= 8'hC0))
         |-> io_rdata == 8'hFF);

   // R10
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_idx && !hit_dat) |-> io_rdata == 8'hFF);

   // R1
   index_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && hit_idx) |=> (!hit_idx || io_rdata == $past(io_wdata)));
endmodule

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        compat_mode = 0;
   logic [7:0]  shadow_region, shadow_ctrl, smm_ctrl;
   logic [15:0] irq_route;
   logic [3:0]  irq_route_en;
   logic        fast_reset_en;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cfg_index_port u_cfg_index_port (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .compat_mode(compat_mode),
      .shadow_region(shadow_region), .shadow_ctrl(shadow_ctrl), .smm_ctrl(smm_ctrl),
      .irq_route(irq_route), .irq_route_en(irq_route_en),
      .fast_reset_en(fast_reset_en));

   // {index, write byte, expected readback}
   localparam logic [23:0] VEC [14] = '{
      24'h14_FF_BF, 24'h2B_FF_BF, 24'h15_FF_F1, 24'h1E_FF_40,
      24'h22_FF_FD, 24'h36_FF_E5, 24'h37_FF_EF, 24'h3D_FF_07,
      24'h40_FF_3F, 24'h10_A5_A5, 24'h42_3B_3B, 24'h19_5A_5A,
      24'h50_77_00, 24'h29_10_10 };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic port_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1;
      @(negedge clk);
      io_wr = 0;
   endtask

   task automatic slot_wr(input logic [7:0] idx, input logic [7:0] d);
      port_wr(16'h0022, idx);
      port_wr(16'h0023, d);
   endtask

   task automatic slot_rd(input logic [7:0] idx, output logic [7:0] d);
      port_wr(16'h0022, idx);
      io_addr = 16'h0023;
      #1 d = io_rdata;
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R7 reset values
      slot_rd(8'h3C, r); check("R7", r, 8'h03);
      slot_rd(8'h3D, r); check("R7", r, 8'h01);
      slot_rd(8'h40, r); check("R7", r, 8'h03);
      slot_rd(8'h03, r); check("R7", r, 8'h00);
      // R1 index readback
      port_wr(16'h0022, 8'h7E); io_addr = 16'h0022; #1 check("R1", io_rdata, 8'h7E);
      // R2 locked write dropped
      slot_wr(8'h10, 8'h66); slot_rd(8'h10, r); check("R2", r, 8'h00);
      // R3 key writable while locked, wrong value stays locked
      slot_wr(8'h03, 8'h12); slot_rd(8'h03, r); check("R3", r, 8'h12);
      slot_wr(8'h10, 8'h66); slot_rd(8'h10, r); check("R2", r, 8'h00);
      slot_wr(8'h03, 8'hC5);
      // R4 R5 vector table
      for (int i = 0; i < 14; i++) begin
         slot_wr(VEC[i][23:16], VEC[i][15:8]);
         slot_rd(VEC[i][23:16], r);
         check((VEC[i][7:0] == VEC[i][15:8]) ? "R5" : "R4", r, VEC[i][7:0]);
      end
      // R8 routing
      slot_wr(8'h43, 8'h0A);
      @(negedge clk);
      check("R8", irq_route, 16'h0A3B);
      check("R8", {12'h0, irq_route_en}, 16'h0007);
      // R9 taps
      slot_wr(8'h13, 8'hC3);
      @(negedge clk);
      check("R9", {15'h0, fast_reset_en}, 16'h0001);
      check("R9", {8'h0, shadow_region}, 16'h00C3);
      check("R9", {8'h0, shadow_ctrl}, 16'h00BF);
      check("R9", {8'h0, smm_ctrl}, 16'h005A);
      slot_wr(8'h29, 8'hEF); @(negedge clk);
      check("R9", {15'h0, fast_reset_en}, 16'h0000);
      // R6 compat hiding
      slot_wr(8'h20, 8'h55);
      slot_rd(8'h20, r); check("R6", r, 8'h55);
      compat_mode = 1;
      slot_rd(8'h20, r); check("R6", r, 8'hFF);
      slot_rd(8'hC0, r); check("R6", r, 8'hFF);
      slot_rd(8'h21, r); check("R6", r, 8'h00);
      compat_mode = 0;
      slot_rd(8'hC0, r); check("R6", r, 8'h00);
      slot_rd(8'h20, r); check("R6", r, 8'h55);
      // R10 unmapped port
      port_wr(16'h0024, 8'h99);
      io_addr = 16'h0024; #1 check("R10", io_rdata, 8'hFF);
      io_addr = 16'h0022; #1 check("R10", io_rdata, 8'h20);
      // R2 relock
      slot_wr(8'h03, 8'h00);
      slot_wr(8'h10, 8'h11); slot_rd(8'h10, r); check("R2", r, 8'hA5);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule